// File: doc/BRIEF.md
# Block-Framed I2C Configuration Slave for a Clock Generator

This block is a serial-bus slave that lets a host read and write the configuration byte bank of a clock generator. It answers one fixed 7-bit device address. Transfers are framed as blocks rather than through a register pointer. A write opens with a command byte and a length byte, and the slave acknowledges both and then discards them. Every byte after those two lands in the next register, starting from register 0. A read opens with a length byte, which the slave supplies, and then streams the registers from register 0 upward.

SCL and SDA are brought into the system clock domain through a short flop chain, and all bus events are detected there: START, STOP and the SCL edges. The slave only pulls SDA low, through an output-enable, and the pad is expected to be open-drain. Some bits in the bank cannot be written. These bits show the inverted values of five frequency-select straps, captured while reset is held. The whole bank is presented in parallel on `cfg_o` for the clock logic to use.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges (drives SDA low in the ninth bit) an address byte 0xD2 (write) or 0xD3 (read), which is device address 1101001 plus the direction bit. Any other address byte is not acknowledged, and the slave then stays silent until the next START.
- R2: In a write, the first two bytes after the address are each acknowledged and change no register.
- R3: From the third byte of a write onward, byte k (counting from 0) is stored in register k, with each byte acknowledged. Bytes beyond the last register are acknowledged and discarded.
- R4: A read returns first the constant 9 (the number of registers), then registers 0 to 8 in order, and then 0xFF for any further byte.
- R5: Bytes move most significant bit first. When the master does not acknowledge a read byte, the transfer ends: the slave releases SDA and drives nothing until the next START. Outside a transfer, `sda_oe` is 0.
- R6: After reset the register values are: byte 0 = 0x00; byte 2, byte 6 and byte 7 = 0xFF; byte 4 = 0x00; byte 8 = 0x03; the writable bits of bytes 1, 3 and 5 are 1.
- R7: Five bits cannot be written. Byte 1 bit 7 = ~s[2], byte 1 bit 6 = ~s[1], byte 1 bit 4 = ~s[0], byte 3 bit 7 = ~s[3] and byte 5 bit 7 = ~s[4], where s is `strap_in` as sampled on the last reset cycle. Writes to these bits and later changes of `strap_in` have no effect on them.
- R8: A STOP or a repeated START at any point ends the current transfer. A partly shifted byte is dropped. A repeated START begins a fresh address phase, and register numbering restarts at 0.
- R9: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the bit rate |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| strap_in | input | 5 | Frequency-select strap levels |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 72 | Register bank; byte k is on bits 8k+7..8k |

## Verification
The assertions assume that SCL and SDA stay stable for several system clocks around every change. They also assume that SDA changes while SCL is high only to form a START or STOP, and that `strap_in` is steady at the end of reset. The bench's master holds each quarter of a bit for ten system clocks. It moves SDA only while SCL is low, except for START and STOP. It issues a repeated START or a STOP only after a byte the slave acknowledged in write mode, or after a read byte it refused, so it never fights a slave that is holding the line low.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } i2c_state_t;

  // Reset value of the writable part of each configuration byte.
  function automatic logic [7:0] cfg_reset_val(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h2F;
      2:       return 8'hFF;
      3:       return 8'h7F;
      4:       return 8'h00;
      5:       return 8'h7F;
      8:       return 8'h03;
      default: return 8'hFF;
    endcase
  endfunction

  // Bits that mirror straps and ignore writes.
  function automatic logic [7:0] cfg_ro_mask(input int idx);
    case (idx)
      1:       return 8'hD0;
      3:       return 8'h80;
      5:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cfg_ro_bits(input int idx, input logic [4:0] s);
    case (idx)
      1:       return {~s[2], ~s[1], 1'b0, ~s[0], 4'b0000};
      3:       return {~s[3], 7'b0};
      5:       return {~s[4], 7'b0};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] scl_q, sda_q;
  logic          scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[NS-2:0], scl_in};
      sda_q <= {sda_q[NS-2:0], sda_in};
      scl_d <= scl_q[NS-1];
      sda_d <= sda_q[NS-1];
    end
  end

  assign scl_s    = scl_q[NS-1];
  assign sda_s    = sda_q[NS-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import clkcfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int AW       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4:0]            strap_in,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] cfg_flat
);
  logic [4:0] strap_q;
  logic [7:0] view [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= cfg_reset_val(g) & ~cfg_ro_mask(g);
      else if (wr_en && (int'(wr_addr) == g))
        q <= wr_data & ~cfg_ro_mask(g);
    end
    assign view[g]            = q | cfg_ro_bits(g, strap_q);
    assign cfg_flat[8*g +: 8] = view[g];
  end

  assign rd_data = (int'(rd_addr) < NUM_REGS) ? view[rd_addr] : 8'hFF;

endmodule

// File: rtl/i2c_blk_fsm.sv
module i2c_blk_fsm
  import clkcfg_i2c_pkg::*;
#(
  parameter int          NUM_REGS = 9,
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  parameter int          AW       = 4,
  parameter int          CW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output logic          busy
);
  localparam logic [CW-1:0] WR_SAT = CW'(NUM_REGS + 2);
  localparam logic [CW-1:0] RD_SAT = CW'(NUM_REGS + 1);

  i2c_state_t    st;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh, nxt_byte;
  logic          addr_ph, rw, ack_ok;
  logic [CW-1:0] wr_cnt, tx_idx;

  // Byte offered to the master on the next load: count, registers, then filler.
  always_comb begin
    if (tx_idx == '0)             nxt_byte = 8'(NUM_REGS);
    else if (tx_idx <= CW'(NUM_REGS)) nxt_byte = rd_data;
    else                          nxt_byte = 8'hFF;
    if (tx_idx == '0 || tx_idx > CW'(NUM_REGS)) rd_addr = '0;
    else                                      rd_addr = AW'(tx_idx - 1'b1);
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr_ph <= 1'b0;
      rw      <= 1'b0;
      ack_ok  <= 1'b0;
      wr_cnt  <= '0;
      tx_idx  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_p) begin
        st      <= ST_RX;
        sda_oe  <= 1'b0;
        bitcnt  <= '0;
        addr_ph <= 1'b1;
        rw      <= 1'b0;
        wr_cnt  <= '0;
        tx_idx  <= '0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (addr_ph) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rw      <= rx_sh[0];
                  addr_ph <= 1'b0;
                  sda_oe  <= 1'b1;
                  st      <= ST_RXACK;
                end else begin
                  sda_oe <= 1'b0;
                  st     <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_RXACK;
                if (wr_cnt >= CW'(2) && wr_cnt < WR_SAT) begin
                  wr_en   <= 1'b1;
                  wr_addr <= AW'(wr_cnt - CW'(2));
                  wr_data <= rx_sh;
                end
                if (wr_cnt != WR_SAT) wr_cnt <= wr_cnt + 1'b1;
              end
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                tx_sh  <= nxt_byte;
                sda_oe <= ~nxt_byte[7];
                if (tx_idx != RD_SAT) tx_idx <= tx_idx + 1'b1;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TXACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_ok) begin
                bitcnt <= '0;
                tx_sh  <= nxt_byte;
                sda_oe <= ~nxt_byte[7];
                if (tx_idx != RD_SAT) tx_idx <= tx_idx + 1'b1;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         NUM_REGS    = 9,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic [4:0]            strap_in,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int AW = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS);
  localparam int CW = $clog2(NUM_REGS + 3);

  logic          sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic          wr_en, busy;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_blk_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .AW(AW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe), .busy(busy)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .strap_in(strap_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_o)
  );

endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk #(
  parameter int NUM_REGS = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_in,
  input logic                  sda_oe,
  input logic                  busy,
  input logic                  stop_p,
  input logic [8*NUM_REGS-1:0] cfg_o
);
  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_in);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !busy);

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_oe);

  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(cfg_o[15:14]) && $stable(cfg_o[12]) &&
                     $stable(cfg_o[31]) && $stable(cfg_o[47])));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .busy(busy), .stop_p(stop_p), .cfg_o(cfg_o)
);

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 9;
  localparam int QB         = 10;   // clocks per quarter bit

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic [4:0] strap_lat = 5'b10110;
  wire        sda_oe;
  wire [8*NREG-1:0] cfg;
  wire        sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .strap_in(strap), .sda_oe(sda_oe), .cfg_o(cfg)
  );

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];
  int n_cmp = 0, n_bad = 0, r9_viol = 0;
  logic [7:0] mreg [NREG];
  bit done = 0;

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      item_t e; logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      n_cmp++;
      if (g !== e.v) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", e.tag, g, e.v);
      end
    end
  end

  // R9 observer: sda_oe may move only while SCL is low
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_d && scl_m) r9_viol++;
    oe_d <= sda_oe;
  end

  task automatic expect_v(input logic [7:0] v, input string tag);
    item_t it; it.v = v; it.tag = tag; exp_q.push_back(it);
  endtask
  task automatic observe(input logic [7:0] v); got_q.push_back(v); endtask
  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    expect_v(exp, tag); observe(act);
  endtask
  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic [7:0] ro_m(input int i);
    case (i) 1: return 8'hD0; 3, 5: return 8'h80; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] ro_v(input int i);
    case (i)
      1: return {~strap_lat[2], ~strap_lat[1], 1'b0, ~strap_lat[0], 4'h0};
      3: return {~strap_lat[3], 7'h0};
      5: return {~strap_lat[4], 7'h0};
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] exp_reg(input int i);
    return (mreg[i] & ~ro_m(i)) | ro_v(i);
  endfunction

  task automatic check_cfg(input string tag);
    wclk(4);
    for (int i = 0; i < NREG; i++) check(cfg[8*i +: 8], exp_reg(i), tag);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wclk(QB); scl_m = 1'b1; wclk(2*QB);
    sda_m = 1'b0; wclk(2*QB); scl_m = 1'b0; wclk(QB);
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; wclk(QB); scl_m = 1'b1; wclk(2*QB);
    sda_m = 1'b1; wclk(2*QB);
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; wclk(QB); scl_m = 1'b1; wclk(2*QB); scl_m = 1'b0; wclk(QB);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(QB); scl_m = 1'b1; wclk(QB); b = sda_line;
    wclk(QB); scl_m = 1'b0; wclk(QB);
  endtask
  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    expect_v({7'b0, exp_ack}, tag);
    get_bit(a);
    observe({7'b0, a});
  endtask
  task automatic recv_byte(input logic [7:0] exp, input logic nack, input string tag);
    logic [7:0] d; logic b;
    expect_v(exp, tag);
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    observe(d);
    send_bit(nack);
  endtask

  task automatic summary();
    wclk(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    mreg[0] = 8'h00; mreg[1] = 8'h2F; mreg[2] = 8'hFF; mreg[3] = 8'h7F; mreg[4] = 8'h00;
    mreg[5] = 8'h7F; mreg[6] = 8'hFF; mreg[7] = 8'hFF; mreg[8] = 8'h03;
    wclk(6);
    rst = 1'b0;
    wclk(2);
    strap = 5'b01001;            // later strap change must not show (R7)
    check_cfg("R6 R7 reset state");
    check({7'b0, sda_oe}, 8'h00, "R5 idle release after reset");

    // full read: count, registers, filler (R4, R1, R5)
    i2c_start();
    send_byte(8'hD3, 1'b0, "R1 read address ack");
    recv_byte(8'd9, 1'b0, "R4 byte count");
    for (int i = 0; i < NREG; i++) recv_byte(exp_reg(i), 1'b0, "R4 R7 read register");
    recv_byte(8'hFF, 1'b0, "R4 filler past end");
    recv_byte(8'hFF, 1'b1, "R4 filler then NACK");
    wclk(QB);
    check({7'b0, sda_oe}, 8'h00, "R5 released after NACK");
    i2c_stop();

    // foreign address (R1)
    i2c_start();
    send_byte(8'hA4, 1'b1, "R1 foreign address not acked");
    send_byte(8'h00, 1'b1, "R1 silent after foreign address");
    i2c_stop();
    check_cfg("R1 no change after foreign address");

    // block write with overflow (R2, R3)
    i2c_start();
    send_byte(8'hD2, 1'b0, "R1 write address ack");
    send_byte(8'h5A, 1'b0, "R2 command byte ack");
    send_byte(8'h33, 1'b0, "R2 count byte ack");
    for (int i = 0; i < NREG + 2; i++) begin
      logic [7:0] d;
      d = 8'hA5 ^ 8'(i * 31);
      send_byte(d, 1'b0, "R3 data byte ack");
      if (i < NREG) mreg[i] = d;
    end
    i2c_stop();
    check_cfg("R3 sequential store");

    // all-zero and all-one writes probe read-only bits (R7)
    for (int p = 0; p < 2; p++) begin
      logic [7:0] d;
      d = (p == 0) ? 8'h00 : 8'hFF;
      i2c_start();
      send_byte(8'hD2, 1'b0, "R1 write address ack");
      send_byte(8'h00, 1'b0, "R2 command byte ack");
      send_byte(8'h00, 1'b0, "R2 count byte ack");
      for (int i = 0; i < NREG; i++) begin send_byte(d, 1'b0, "R3 data byte ack"); mreg[i] = d; end
      i2c_stop();
      check_cfg("R7 strap bits ignore writes");
    end

    // command and count only (R2)
    i2c_start();
    send_byte(8'hD2, 1'b0, "R1 write address ack");
    send_byte(8'h00, 1'b0, "R2 command byte ack");
    send_byte(8'h00, 1'b0, "R2 count byte ack");
    i2c_stop();
    check_cfg("R2 command and count ignored");

    // STOP in the middle of a byte (R8)
    i2c_start();
    send_byte(8'hD2, 1'b0, "R1 write address ack");
    send_byte(8'h00, 1'b0, "R2 command byte ack");
    send_byte(8'h00, 1'b0, "R2 count byte ack");
    send_byte(8'h12, 1'b0, "R3 data byte ack");
    mreg[0] = 8'h12;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    check_cfg("R8 partial byte dropped on STOP");

    // repeated START restarts numbering (R8)
    i2c_start();
    send_byte(8'hD2, 1'b0, "R1 write address ack");
    send_byte(8'h00, 1'b0, "R2 command byte ack");
    send_byte(8'h00, 1'b0, "R2 count byte ack");
    send_byte(8'h34, 1'b0, "R3 data byte ack");
    mreg[0] = 8'h34;
    i2c_start();
    send_byte(8'hD3, 1'b0, "R8 read address after repeated START");
    recv_byte(8'd9, 1'b0, "R8 count after repeated START");
    recv_byte(exp_reg(0), 1'b1, "R8 register 0 after repeated START");
    i2c_start();
    send_byte(8'hD2, 1'b0, "R8 write address after repeated START");
    send_byte(8'hFF, 1'b0, "R2 command byte ack");
    send_byte(8'hFF, 1'b0, "R2 count byte ack");
    send_byte(8'h56, 1'b0, "R3 data byte ack");
    mreg[0] = 8'h56;
    i2c_stop();
    check_cfg("R8 write restarts at register 0");
    check({7'b0, sda_oe}, 8'h00, "R5 idle release at end");
    check(8'(r9_viol), 8'h00, "R9 sda_oe moved while SCL high");

    wclk(20);
    done = 1;
    summary();
    $finish;
  end

endmodule